// File: doc/BRIEF.md
# Central Bus Arbiter with Two Priority Levels

This block decides which of six requesters may own a shared parallel bus: five external masters, each with its own request and grant line, and one internal host device. A configuration bit per requester puts it in a high or a low priority group. Inside a group, requesters are served in rotating order, and every high-group requester goes before any low-group requester. Arbitration is per transaction: the rotation advances only when a granted requester actually starts a transaction, so a master must request and win again for each access.

When nobody requests, the bus is parked either on the requester that last used it or on the host, as selected by configuration. An optional watchdog locks out a master that keeps its request and grant for 16 idle bus clocks without starting a transaction. From then on its request is ignored until the configuration register is written or the block is reset. A strap input chooses at reset whether the block arbitrates at all. When arbitration is off, the host's request is passed out to an external arbiter and the grant that comes back is handed to the host.

The configuration word is 9 bits wide (bit positions are listed in R10). A write replaces all of it and clears every lockout. The lockout state of each master can be read on its own output.

Top module: `bus_arbiter`

## Requirements
- R1: At most one of the six grant outputs (host_gnt, gnt[4:0]) is high in any cycle.
- R2: Configuration bits [4:0] are the master priorities: bit 4 belongs to req[0] and bit 0 to req[4]. Bit 5 is the host priority. A 1 means high priority. A requesting high-group member is always granted ahead of any low-group member.
- R3: Within a group, the grant goes to the first requester after the last one that started a transaction, in index order 0..4 then host (index 5), wrapping around. After reset, both groups start their search at index 0.
- R4: While frame_act is high, the grant does not change. A new grant is issued one clock after a cycle in which frame_act is low.
- R5: With nothing eligible requesting, the grant goes to the last requester that started a transaction (the host after reset) if config bit 7 is 0, and to the host if bit 7 is 1.
- R6: With config bit 6 at 0, a master that holds the grant and keeps requesting while frame_act and irdy_act are both low for 16 consecutive clocks gets its brk_lock bit set at the 16th edge. From then on its request is ignored.
- R7: With config bit 6 at 1, no lockout ever occurs.
- R8: A configuration write clears all brk_lock bits, so locked masters can win grants again.
- R9: With config bit 8 at 1, gnt[4:0] stays 0, ext_req follows host_req, and host_gnt follows ext_gnt.
- R10: Reset clears config bits [7:0], all grants and all lockouts. Config bit 8 resets to the inverse of strap_arb_en. cfg_rdata reads the configuration as bit 8 arbiter off, bit 7 park on host, bit 6 lockout disable, bit 5 host priority, bits 4:0 master priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_arb_en | input | 1 | Strap: 1 makes this block the arbiter after reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration write data |
| cfg_rdata | output | 9 | Current configuration |
| brk_lock | output | 5 | Per-master lockout status |
| req | input | 5 | External master requests, active high |
| gnt | output | 5 | External master grants, active high |
| host_req | input | 1 | Internal host request |
| host_gnt | output | 1 | Internal host grant |
| ext_req | output | 1 | Host request forwarded to an external arbiter |
| ext_gnt | input | 1 | Grant from an external arbiter |
| frame_act | input | 1 | A transaction is in its address or data phases |
| irdy_act | input | 1 | Initiator ready; high with frame_act low marks the last data phase |

## Verification
The assertions assume that frame_act is raised only by the current grant holder, and that the external grant arrives only while the block is in pass-through mode. The stimulus raises frame_act only after checking which master holds the grant, and it drives ext_gnt only after the strap has turned arbitration off. The grant-hold property assumes that no configuration write lands during a transaction. The bench writes configuration only while the bus is idle.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NM       = 5,
  parameter int BRK_CLKS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_arb_en,
  input  logic          cfg_we,
  input  logic [NM+3:0] cfg_wdata,
  output logic [NM+3:0] cfg_rdata,
  output logic [NM-1:0] brk_lock,
  input  logic [NM-1:0] req,
  output logic [NM-1:0] gnt,
  input  logic          host_req,
  output logic          host_gnt,
  output logic          ext_req,
  input  logic          ext_gnt,
  input  logic          frame_act,
  input  logic          irdy_act
);
  localparam int NR = NM + 1;
  localparam int IW = $clog2(NR);
  localparam int CW = $clog2(BRK_CLKS);
  localparam logic [IW-1:0] HOST = IW'(NM);

  logic          arb_off, park_host, brk_dis, host_hi;
  logic [NM-1:0] mprio, lock_q;
  logic [NR-1:0] gnt_q, gnt_d, hi_mask, elig;
  logic [IW-1:0] ptr_hi, ptr_lo, last_user, holder, winner;
  logic [IW:0]   pick_hi, pick_lo;
  logic [CW-1:0] brk_cnt;
  logic          found, brk_run;

  function automatic logic [IW:0] rr_pick(input logic [NR-1:0] m, input logic [IW-1:0] p);
    rr_pick = '0;
    for (int k = NR; k >= 1; k--) begin
      int idx;
      idx = (int'(p) + k) % NR;
      if (m[idx]) rr_pick = {1'b1, IW'(idx)};
    end
  endfunction

  always_comb begin
    for (int i = 0; i < NM; i++) hi_mask[i] = mprio[NM-1-i];
    hi_mask[NM] = host_hi;
  end

  assign elig    = {host_req, req} & ~{1'b0, lock_q};
  assign pick_hi = rr_pick(elig & hi_mask, ptr_hi);
  assign pick_lo = rr_pick(elig & ~hi_mask, ptr_lo);
  assign found   = pick_hi[IW] | pick_lo[IW];
  assign winner  = pick_hi[IW] ? pick_hi[IW-1:0] : pick_lo[IW-1:0];

  always_comb begin
    holder = '0;
    for (int i = 0; i < NR; i++) if (gnt_q[i]) holder = IW'(i);
  end

  always_comb begin
    gnt_d = gnt_q;
    if (arb_off) gnt_d = '0;
    else if (!frame_act) begin
      gnt_d = '0;
      if (found) gnt_d[winner] = 1'b1;
      else gnt_d[park_host ? HOST : last_user] = 1'b1;
    end
  end

  assign brk_run = !arb_off && !brk_dis && !frame_act && !irdy_act && (gnt_d == gnt_q)
                   && |(gnt_q[NM-1:0] & req & ~lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_off   <= ~strap_arb_en;
      park_host <= 1'b0;
      brk_dis   <= 1'b0;
      host_hi   <= 1'b0;
      mprio     <= '0;
      gnt_q     <= '0;
      lock_q    <= '0;
      ptr_hi    <= HOST;
      ptr_lo    <= HOST;
      last_user <= HOST;
      brk_cnt   <= '0;
    end else begin
      gnt_q <= gnt_d;
      if (cfg_we) {arb_off, park_host, brk_dis, host_hi, mprio} <= cfg_wdata;
      if (frame_act && |gnt_q) begin
        last_user <= holder;
        if (hi_mask[holder]) ptr_hi <= holder;
        else ptr_lo <= holder;
      end
      if (cfg_we || !brk_run) brk_cnt <= '0;
      else if (brk_cnt == CW'(BRK_CLKS - 1)) begin
        brk_cnt        <= '0;
        lock_q[holder] <= 1'b1;
      end else brk_cnt <= brk_cnt + 1'b1;
      if (cfg_we) lock_q <= '0;
    end
  end

  assign gnt       = arb_off ? '0 : gnt_q[NM-1:0];
  assign host_gnt  = arb_off ? ext_gnt : gnt_q[NM];
  assign ext_req   = arb_off & host_req;
  assign cfg_rdata = {arb_off, park_host, brk_dis, host_hi, mprio};
  assign brk_lock  = lock_q;
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int NM = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [NM+3:0] cfg_rdata,
  input logic [NM-1:0] brk_lock,
  input logic [NM-1:0] gnt,
  input logic          host_gnt,
  input logic          host_req,
  input logic          ext_req,
  input logic          ext_gnt,
  input logic          frame_act
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_gnt, gnt})); // R1

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_act && !cfg_we && !cfg_rdata[NM+3] |=> $stable({host_gnt, gnt})); // R4

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[NM+3] |-> (gnt == '0) && (host_gnt == ext_gnt) && (ext_req == host_req)); // R9

  AST_NO_LOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[NM+1] |-> brk_lock == '0); // R7
endmodule

bind bus_arbiter bus_arbiter_chk #(.NM(NM)) u_chk (.*);

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;
  logic       clk = 0, rst_n = 0, strap_arb_en = 1;
  logic       cfg_we = 0;
  logic [8:0] cfg_wdata = '0, cfg_rdata;
  logic [4:0] brk_lock, req = '0, gnt;
  logic       host_req = 0, host_gnt, ext_req, ext_gnt = 0, frame_act = 0, irdy_act = 0;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  bus_arbiter u_bus_arbiter (.*);

  // {cfg[8:0], req[4:0], host_req, expected {host_gnt, gnt}}
  localparam logic [20:0] VEC [8] = '{
    {9'b0_0_1_0_00000, 5'b00110, 1'b0, 6'b000010},
    {9'b0_0_1_0_00100, 5'b00110, 1'b0, 6'b000100},
    {9'b0_0_1_1_00000, 5'b11111, 1'b1, 6'b100000},
    {9'b0_0_1_0_00001, 5'b10001, 1'b0, 6'b010000},
    {9'b0_0_1_0_10000, 5'b01001, 1'b0, 6'b000001},
    {9'b0_1_1_0_00000, 5'b00000, 1'b0, 6'b100000},
    {9'b0_0_1_1_11111, 5'b11000, 1'b1, 6'b001000},
    {9'b0_0_1_0_00000, 5'b00000, 1'b1, 6'b100000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wcfg(input logic [8:0] v);
    cfg_we = 1;
    cfg_wdata = v;
    tick();
    cfg_we = 0;
  endtask

  task automatic txn(input logic [5:0] holder);
    frame_act = 1;
    irdy_act = 1;
    tick();
    chk("R4 grant held during frame", {host_gnt, gnt}, holder);
    frame_act = 0;
    tick();
    irdy_act = 0;
    tick();
  endtask

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R10 cfg reset", cfg_rdata, 9'h000);
    chk("R10 grants reset", {host_gnt, gnt}, 6'b0);
    chk("R10 locks reset", brk_lock, 5'b0);

    foreach (VEC[i]) begin
      req = VEC[i][11:7];
      host_req = VEC[i][6];
      wcfg(VEC[i][20:12]);
      tick();
      chk($sformatf("R2 R5 vector %0d", i), {host_gnt, gnt}, VEC[i][5:0]);
      chk("R1 onehot", $onehot0({host_gnt, gnt}), 1);
    end

    host_req = 0;
    req = 5'b00111;
    wcfg(9'b0_0_1_1_11111);
    tick();
    chk("R3 first in rotation", {host_gnt, gnt}, 6'b000001);
    txn(6'b000001);
    chk("R3 rotate to req1", {host_gnt, gnt}, 6'b000010);
    txn(6'b000010);
    chk("R3 rotate to req2", {host_gnt, gnt}, 6'b000100);
    txn(6'b000100);
    chk("R3 wrap to req0", {host_gnt, gnt}, 6'b000001);

    req = 0;
    wcfg(9'b0_0_1_0_00000);
    tick();
    chk("R5 park on last user", {host_gnt, gnt}, 6'b000100);
    wcfg(9'b0_1_1_0_00000);
    tick();
    chk("R5 park on host", {host_gnt, gnt}, 6'b100000);

    req = 5'b01000;
    wcfg(9'b0_1_0_0_00000);
    repeat (15) tick();
    chk("R6 no lock before 16 clocks", brk_lock, 5'b00000);
    tick();
    chk("R6 lock at 16 clocks", brk_lock, 5'b01000);
    tick();
    chk("R6 locked request ignored", {host_gnt, gnt}, 6'b100000);
    wcfg(9'b0_1_0_0_00000);
    chk("R8 write clears lock", brk_lock, 5'b00000);
    tick();
    chk("R8 master granted again", {host_gnt, gnt}, 6'b001000);
    wcfg(9'b0_1_1_0_00000);
    repeat (40) tick();
    chk("R7 no lock when disabled", brk_lock, 5'b00000);
    chk("R7 grant kept", {host_gnt, gnt}, 6'b001000);

    rst_n = 0;
    strap_arb_en = 0;
    tick();
    rst_n = 1;
    #1;
    chk("R10 strap sets arbiter off", cfg_rdata[8], 1);
    req = 5'b11111;
    host_req = 1;
    ext_gnt = 1;
    tick();
    chk("R9 request forwarded", ext_req, 1);
    chk("R9 external grant to host", host_gnt, 1);
    chk("R9 no master grants", gnt, 5'b0);
    ext_gnt = 0;
    #1;
    chk("R9 external grant dropped", host_gnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule